// File: doc/BRIEF.md
# Banked Memory Address Mapper

This block sits on the cartridge side of an 8-bit console and turns narrow CPU and picture-processor fetch addresses into wide physical addresses for large program and pattern memories. The CPU programs it by writing to the upper half of its address map. A control register selects which bank register the next data write loads. It also selects one of two program layouts and whether the two 4 KB pattern halves are swapped. A separate register, written through a window in the low address range, supplies one extra high bank bit for each half of the pattern space. A mirroring select is kept for the nametable logic.

The program side has four 8 KB windows. Two are set by software and two are fixed to the last two banks of the memory. The pattern side has eight 1 KB windows, fed by two 2 KB registers and four 1 KB registers. Bank numbers are formed combinationally from the stored registers, so a write is visible on the first fetch after the clock edge that captures it. Two configuration straps select four-screen operation and pattern RAM in place of pattern ROM.

Top module: `bank_xlate`

## Requirements
- R1: A CPU write with `cpu_addr[15]` set is decoded only from address bits 15, 14, 13 and 0. Slot {A14,A13,A0} = 000 is the control register, 001 is the bank data port and 010 is the mirroring register. Every alias of an address behaves the same (for example 0x9FFE acts as 0x8000).
- R2: A write to the bank data port loads the bank register chosen by `ctrl[2:0]`. Index 0 and 1 are 2 KB pattern banks and store the data with bit 0 cleared. Index 2..5 are 1 KB pattern banks. Index 6 and 7 are program banks P0 and P1.
- R3: Program window `prg_addr_in[14:13]` = 0,1,2,3 maps to banks P0, P1, last-1, last when `ctrl[6]` = 0, and to last-1, P1, P0, last when `ctrl[6]` = 1. `prg_phys` = {bank[PRG_BANK_W-1:0], prg_addr_in[12:0]}.
- R4: With `ctrl[7]` = 0, pattern windows 0..3 (`chr_addr_in[12:10]`) come from the 2 KB pair and windows 4..7 come from 1 KB banks 2..5 in order. With `ctrl[7]` = 1, the two halves trade places.
- R5: A CPU write to an address strictly above 0x4100 and strictly below 0x6000 stores data bit 0 as the high bank bit (value 256) of windows 0..3 and data bit 4 as that of windows 4..7. The bits belong to the physical half, whatever the swap. Writes at 0x4100 or 0x6000 leave them unchanged.
- R6: The 2 KB bank for index i covers two 1 KB windows: the lower one uses the stored even number and the upper one uses that number plus one.
- R7: Bit 0 of a mirroring write drives `mirror_h` (1 horizontal, 0 vertical). While `cfg_four_screen` = 1, mirroring writes leave `mirror_h` unchanged.
- R8: After synchronous reset, the control register, both high bits and `mirror_h` are 0. P0 = 0 and P1 = 1. The 2 KB banks are 0 and 2, and the 1 KB banks are 4, 5, 6 and 7.
- R9: While `cpu_rd` is high and the address lies strictly between 0x4100 and 0x6000, `rd_oe` is 1 and `rd_data` is 0x01. Otherwise `rd_oe` is 0.
- R10: With `cfg_chr_ram` = 1, every 1 KB pattern bank number is reduced to its low 3 bits and the high bits are ignored. `chr_phys` = {bank[8:0], `chr_addr_in[9:0]`}.
- R11: Writes to the remaining slots (0xA001, 0xC000, 0xC001, 0xE000, 0xE001) change no output. A register write is reflected in `prg_phys` and `chr_phys` during the first cycle after the capturing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| cpu_rd | input | 1 | CPU read strobe |
| cfg_four_screen | input | 1 | Strap: four-screen nametables, mirroring writes ignored |
| cfg_chr_ram | input | 1 | Strap: pattern memory is 8 KB RAM |
| prg_addr_in | input | 15 | Program fetch address within 0x8000..0xFFFF |
| chr_addr_in | input | 13 | Pattern fetch address |
| prg_phys | output | PRG_BANK_W+13 | Physical program address |
| chr_phys | output | 19 | Physical pattern address |
| mirror_h | output | 1 | Mirroring select, 1 = horizontal |
| rd_data | output | 8 | Read data for the low range |
| rd_oe | output | 1 | Drive enable for `rd_data` |

## Verification
The assertions assume that the configuration straps do not change in the same cycle as a mirroring write. They also assume that `rst` is held high from time zero until the first clock edge, so that the post-reset checks start from a defined register state. The stimulus sets the straps only while `cpu_wr` is low, and it issues each write as a single-cycle strobe separated by idle cycles. The reference model therefore always sees one register change at a time.

// File: rtl/bmx_pkg.sv
package bmx_pkg;
  localparam int NUM_BANK_REGS = 8;
  localparam int CHR_BANK_W    = 9;

  typedef logic [NUM_BANK_REGS-1:0][7:0] bank_arr_t;

  typedef enum logic [2:0] {
    SLOT_CTRL = 3'd0,
    SLOT_DATA = 3'd1,
    SLOT_MIRR = 3'd2,
    SLOT_NOP3 = 3'd3,
    SLOT_NOP4 = 3'd4,
    SLOT_NOP5 = 3'd5,
    SLOT_NOP6 = 3'd6,
    SLOT_NOP7 = 3'd7
  } slot_e;

  localparam logic [2:0] IDX_PRG0 = 3'd6;
  localparam logic [2:0] IDX_PRG1 = 3'd7;

  function automatic logic in_low_window(input logic [15:0] a);
    return (a > 16'h4100) && (a < 16'h6000);
  endfunction

  function automatic logic [7:0] bank_reset_val(input int i);
    if (i == 0)      return 8'd0;
    else if (i == 1) return 8'd2;
    else if (i < 6)  return 8'(i + 2);
    else             return 8'(i - 6);
  endfunction
endpackage

// File: rtl/bmx_regs.sv
module bmx_regs
  import bmx_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] cpu_addr,
  input  logic [7:0]  cpu_wdata,
  input  logic        cpu_wr,
  input  logic        cfg_four_screen,
  output logic [7:0]  ctrl_q,
  output bank_arr_t   banks_q,
  output logic        hi_lo_q,
  output logic        hi_up_q,
  output logic        mirror_q
);
  slot_e slot;
  logic  hi_wr;
  logic  cart_wr;

  assign cart_wr = cpu_wr && cpu_addr[15];
  assign slot    = slot_e'({cpu_addr[14:13], cpu_addr[0]});
  assign hi_wr   = cpu_wr && in_low_window(cpu_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= 8'd0;
      mirror_q <= 1'b0;
      for (int i = 0; i < NUM_BANK_REGS; i++) begin
        banks_q[i] <= bank_reset_val(i);
      end
    end else if (cart_wr) begin
      case (slot)
        SLOT_CTRL: ctrl_q <= cpu_wdata;
        SLOT_DATA: begin
          if (ctrl_q[2:1] == 2'b00)
            banks_q[ctrl_q[2:0]] <= {cpu_wdata[7:1], 1'b0};
          else
            banks_q[ctrl_q[2:0]] <= cpu_wdata;
        end
        SLOT_MIRR: if (!cfg_four_screen) mirror_q <= cpu_wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_lo_q <= 1'b0;
      hi_up_q <= 1'b0;
    end else if (hi_wr) begin
      hi_lo_q <= cpu_wdata[0];
      hi_up_q <= cpu_wdata[4];
    end
  end

  // R8: registers come out of reset at their defined values
  a_r8_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ctrl_q == 8'd0 && !hi_lo_q && !hi_up_q && !mirror_q &&
                    banks_q[IDX_PRG0] == 8'd0 && banks_q[IDX_PRG1] == 8'd1));

  // R5: high bits only move on a write inside the low window
  a_r5_hi_only_low: assert property (@(posedge clk) disable iff (rst)
    !hi_wr |=> ($stable(hi_lo_q) && $stable(hi_up_q)));

  // R2: 2 KB registers never hold an odd number
  a_r2_pair_even: assert property (@(posedge clk) disable iff (rst)
    (cart_wr && slot == SLOT_DATA && ctrl_q[2:1] == 2'b00) |=> !banks_q[$past(ctrl_q[2:0])][0]);

  // R11: writes to the unused slots keep control and mirroring intact
  a_r11_nop_slots: assert property (@(posedge clk) disable iff (rst)
    (cart_wr && slot >= SLOT_NOP3) |=> ($stable(ctrl_q) && $stable(mirror_q) && $stable(banks_q)));
endmodule

// File: rtl/bmx_prg_map.sv
module bmx_prg_map #(
  parameter int PRG_BANK_W = 6
) (
  input  logic [7:0]            ctrl,
  input  logic [7:0]            prg0,
  input  logic [7:0]            prg1,
  input  logic [14:0]           addr_in,
  output logic [PRG_BANK_W+12:0] phys
);
  localparam logic [PRG_BANK_W-1:0] LAST_BANK   = '1;
  localparam logic [PRG_BANK_W-1:0] SECOND_LAST = LAST_BANK - 1'b1;

  logic [PRG_BANK_W-1:0] bank;
  logic                  alt_layout;

  assign alt_layout = ctrl[6];

  always_comb begin
    case (addr_in[14:13])
      2'd0:    bank = alt_layout ? SECOND_LAST : prg0[PRG_BANK_W-1:0];
      2'd1:    bank = prg1[PRG_BANK_W-1:0];
      2'd2:    bank = alt_layout ? prg0[PRG_BANK_W-1:0] : SECOND_LAST;
      default: bank = LAST_BANK;
    endcase
  end

  assign phys = {bank, addr_in[12:0]};
endmodule

// File: rtl/bmx_chr_map.sv
module bmx_chr_map
  import bmx_pkg::*;
(
  input  logic                    swap,
  input  bank_arr_t               banks,
  input  logic                    hi_lo,
  input  logic                    hi_up,
  input  logic                    chr_ram,
  input  logic [12:0]             addr_in,
  output logic [CHR_BANK_W+9:0]   phys
);
  logic [2:0]            win;
  logic                  pair_side;
  logic [7:0]            base;
  logic [7:0]            num8;
  logic                  hi_bit;
  logic [CHR_BANK_W-1:0] num;

  assign win       = addr_in[12:10];
  assign pair_side = ~(win[2] ^ swap);

  always_comb begin
    if (pair_side) begin
      base = banks[{2'b00, win[1]}];
      num8 = {base[7:1], win[0]};
    end else begin
      base = banks[3'd2 + {1'b0, win[1:0]}];
      num8 = base;
    end
    hi_bit = win[2] ? hi_up : hi_lo;
    if (chr_ram)
      num = {{(CHR_BANK_W-3){1'b0}}, num8[2:0]};
    else
      num = {hi_bit, num8};
  end

  assign phys = {num, addr_in[9:0]};
endmodule

// File: rtl/bank_xlate.sv
module bank_xlate
  import bmx_pkg::*;
#(
  parameter int PRG_BANK_W = 6
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [15:0]               cpu_addr,
  input  logic [7:0]                cpu_wdata,
  input  logic                      cpu_wr,
  input  logic                      cpu_rd,
  input  logic                      cfg_four_screen,
  input  logic                      cfg_chr_ram,
  input  logic [14:0]               prg_addr_in,
  input  logic [12:0]               chr_addr_in,
  output logic [PRG_BANK_W+12:0]    prg_phys,
  output logic [CHR_BANK_W+9:0]     chr_phys,
  output logic                      mirror_h,
  output logic [7:0]                rd_data,
  output logic                      rd_oe
);
  localparam int PRG_TOP = PRG_BANK_W + 12;

  logic [7:0] ctrl_q;
  bank_arr_t  banks_q;
  logic       hi_lo_q;
  logic       hi_up_q;

  bmx_regs u_regs (
    .clk             (clk),
    .rst             (rst),
    .cpu_addr        (cpu_addr),
    .cpu_wdata       (cpu_wdata),
    .cpu_wr          (cpu_wr),
    .cfg_four_screen (cfg_four_screen),
    .ctrl_q          (ctrl_q),
    .banks_q         (banks_q),
    .hi_lo_q         (hi_lo_q),
    .hi_up_q         (hi_up_q),
    .mirror_q        (mirror_h)
  );

  bmx_prg_map #(.PRG_BANK_W(PRG_BANK_W)) u_prg (
    .ctrl    (ctrl_q),
    .prg0    (banks_q[IDX_PRG0]),
    .prg1    (banks_q[IDX_PRG1]),
    .addr_in (prg_addr_in),
    .phys    (prg_phys)
  );

  bmx_chr_map u_chr (
    .swap    (ctrl_q[7]),
    .banks   (banks_q),
    .hi_lo   (hi_lo_q),
    .hi_up   (hi_up_q),
    .chr_ram (cfg_chr_ram),
    .addr_in (chr_addr_in),
    .phys    (chr_phys)
  );

  assign rd_oe   = cpu_rd && in_low_window(cpu_addr);
  assign rd_data = 8'h01;

  // R3: the top window is always the last bank
  a_r3_last_window: assert property (@(posedge clk) disable iff (rst)
    (prg_addr_in[14:13] == 2'b11) |-> (prg_phys[PRG_TOP:13] == {PRG_BANK_W{1'b1}}));

  // R7: four-screen operation freezes the mirroring select
  a_r7_four_screen_hold: assert property (@(posedge clk) disable iff (rst)
    (cfg_four_screen && cpu_wr) |=> $stable(mirror_h));

  // R9: the low window read value is constant
  a_r9_low_read: assert property (@(posedge clk) disable iff (rst)
    rd_oe |-> (rd_data == 8'h01));

  // R10: pattern RAM keeps bank numbers inside 8 KB
  a_r10_ram_mask: assert property (@(posedge clk) disable iff (rst)
    cfg_chr_ram |-> (chr_phys[CHR_BANK_W+9:13] == '0));
endmodule

// File: tb/bank_xlate_tb.sv
`timescale 1ns/1ps
module bank_xlate_tb;
  localparam int PRG_BANK_W = 6;
  localparam int PRG_BANKS  = 1 << PRG_BANK_W;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = 16'h0000;
  logic [7:0]  cpu_wdata = 8'h00;
  logic        cpu_wr = 1'b0;
  logic        cpu_rd = 1'b0;
  logic        cfg_four_screen = 1'b0;
  logic        cfg_chr_ram = 1'b0;
  logic [14:0] prg_addr_in = 15'd0;
  logic [12:0] chr_addr_in = 13'd0;
  logic [PRG_BANK_W+12:0] prg_phys;
  logic [18:0] chr_phys;
  logic        mirror_h;
  logic [7:0]  rd_data;
  logic        rd_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state
  int m_ctrl;
  int m_bank[8];
  int m_hlo, m_hup, m_mir;

  always #2.5 clk = ~clk;

  bank_xlate #(.PRG_BANK_W(PRG_BANK_W)) u_dut (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cfg_four_screen(cfg_four_screen),
    .cfg_chr_ram(cfg_chr_ram), .prg_addr_in(prg_addr_in),
    .chr_addr_in(chr_addr_in), .prg_phys(prg_phys), .chr_phys(chr_phys),
    .mirror_h(mirror_h), .rd_data(rd_data), .rd_oe(rd_oe)
  );

  task automatic model_reset();
    m_ctrl = 0; m_hlo = 0; m_hup = 0; m_mir = 0;
    m_bank[0] = 0; m_bank[1] = 2; m_bank[2] = 4; m_bank[3] = 5;
    m_bank[4] = 6; m_bank[5] = 7; m_bank[6] = 0; m_bank[7] = 1;
  endtask

  task automatic model_write(input int a, input int d);
    if (a >= 'h8000) begin
      case (((a >> 12) & 'h6) | (a & 1))
        0: m_ctrl = d;
        1: m_bank[m_ctrl & 7] = ((m_ctrl & 7) < 2) ? (d & 'hFE) : d;
        2: if (!cfg_four_screen) m_mir = d & 1;
        default: ;
      endcase
    end else if (a > 'h4100 && a < 'h6000) begin
      m_hlo = d & 1;
      m_hup = (d >> 4) & 1;
    end
  endtask

  function automatic int exp_prg(input int a);
    int w, b;
    w = (a >> 13) & 3;
    case (w)
      0: b = ((m_ctrl >> 6) & 1) ? PRG_BANKS - 2 : m_bank[6];
      1: b = m_bank[7];
      2: b = ((m_ctrl >> 6) & 1) ? m_bank[6] : PRG_BANKS - 2;
      default: b = PRG_BANKS - 1;
    endcase
    b = b % PRG_BANKS;
    return b * 8192 + (a & 8191);
  endfunction

  function automatic int exp_chr(input int a);
    int w, ph, b;
    w  = (a >> 10) & 7;
    ph = w >> 2;
    if ((ph ^ ((m_ctrl >> 7) & 1)) == 0) b = m_bank[(w >> 1) & 1] + (w & 1);
    else                                  b = m_bank[2 + (w & 3)];
    b = b + 256 * (ph ? m_hup : m_hlo);
    if (cfg_chr_ram) b = b & 7;
    return b * 1024 + (a & 1023);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cpu_write(input int a, input int d);
    @(negedge clk);
    cpu_addr  = 16'(a);
    cpu_wdata = 8'(d);
    cpu_wr    = 1'b1;
    @(negedge clk);
    cpu_wr    = 1'b0;
    model_write(a, d);
  endtask

  // probe every window right after the write edge (R11 timing)
  task automatic check_all(input string req);
    for (int w = 0; w < 4; w++) begin
      prg_addr_in = 15'(w * 8192 + 'h155 + w);
      #0.5;
      check(req, int'(prg_phys), exp_prg(int'(prg_addr_in)));
    end
    for (int w = 0; w < 8; w++) begin
      chr_addr_in = 13'(w * 1024 + 'h2A + w);
      #0.5;
      check(req, int'(chr_phys), exp_chr(int'(chr_addr_in)));
    end
    check(req, int'(mirror_h), m_mir);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_all("R8");

    // R2/R6: load all bank registers, odd values into the 2 KB pair
    for (int i = 0; i < 8; i++) begin
      cpu_write('h8000, i);
      cpu_write('h8001, 'h11 + 'h13 * i);
      check_all("R2");
    end
    cpu_write('h8000, 0); cpu_write('h8001, 'h33); check_all("R6");

    // R3: alternate program layout
    cpu_write('h8000, 'h40); check_all("R3");
    cpu_write('h8000, 'h46); cpu_write('h8001, 'h7E); check_all("R3");

    // R4: pattern half swap
    cpu_write('h8000, 'h80); check_all("R4");
    cpu_write('h8000, 'hC1); cpu_write('h8001, 'h9B); check_all("R4");

    // R5: high bits at window boundaries, with and without swap
    cpu_write('h4101, 'h01); check_all("R5");
    cpu_write('h4100, 'h10); check_all("R5");
    cpu_write('h6000, 'h11); check_all("R5");
    cpu_write('h5FFF, 'h10); check_all("R5");
    cpu_write('h8000, 'h00); check_all("R5");

    // R1: aliases decoded from A15, A14, A13, A0 only
    cpu_write('h9FFE, 'h85); check_all("R1");
    cpu_write('h8F03, 'h44); check_all("R1");
    cpu_write('hBFFE, 'h01); check_all("R1");

    // R7: mirroring, then four-screen hold
    cpu_write('hA000, 'h00); check_all("R7");
    cpu_write('hA000, 'hFF); check_all("R7");
    @(negedge clk) cfg_four_screen = 1'b1;
    cpu_write('hA000, 'h00); check_all("R7");
    @(negedge clk) cfg_four_screen = 1'b0;

    // R11: unused slots have no effect
    cpu_write('hA001, 'hFF); cpu_write('hC000, 'h55);
    cpu_write('hC001, 'hAA); cpu_write('hE000, 'h00);
    cpu_write('hE001, 'hFF); check_all("R11");

    // R10: pattern RAM masking
    cpu_write('h4200, 'h11);
    @(negedge clk) cfg_chr_ram = 1'b1;
    #0.5 check_all("R10");
    cpu_write('h8000, 'h80); check_all("R10");
    @(negedge clk) cfg_chr_ram = 1'b0;
    #0.5 check_all("R10");

    // R9: low range reads
    @(negedge clk);
    cpu_rd = 1'b1;
    cpu_addr = 16'h5000; #0.5;
    check("R9", int'(rd_oe), 1); check("R9", int'(rd_data), 1);
    cpu_addr = 16'h4100; #0.5;
    check("R9", int'(rd_oe), 0);
    cpu_addr = 16'h6000; #0.5;
    check("R9", int'(rd_oe), 0);
    cpu_addr = 16'h4101; #0.5;
    check("R9", int'(rd_oe), 1);
    cpu_rd = 1'b0; #0.5;
    check("R9", int'(rd_oe), 0);

    // R8: a second reset restores defaults
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    model_reset();
    check_all("R8");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule